// File: doc/BRIEF.md
# Pin Interrupt Detector

This block watches a bank of already-synchronized input pins and turns selected pin activity into interrupt requests. Each pin has its own control word in a small register space. A four-bit trigger code inside that word chooses what the pin reports: nothing, a held low level, a held high level, a low-to-high change, a high-to-low change, or any change. Edges are found by comparing each pin's present sample with the sample from the previous clock.

Detected events set bits in one shared status word, one bit per pin. Software clears a bit by writing a one to it. The OR of all status bits is registered and drives a single interrupt line. A level trigger sets its bit again on every cycle the level lasts, so clearing it while the level persists has no lasting effect. If an event and a clear hit the same bit in one cycle, the event wins.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every trigger code is 0, every status bit is 0 and `irqOut` is 0.
- R2: The control word of pin n (0 to 31) is at byte address 4*n. Its trigger code is written from and read back at bits 19:16. All other bits of a control word read as 0.
- R3: Trigger code 0x0, and any code not listed in R4 to R8, never sets a status bit. Writing zero to a control word therefore masks that pin.
- R4: Code 0x8 sets the pin's status bit on every cycle in which the pin is low.
- R5: Code 0xC sets the pin's status bit on every cycle in which the pin is high.
- R6: Code 0x9 sets the status bit when the pin is 1 and was 0 in the previous cycle. The bit stays set after the pin stops changing.
- R7: Code 0xA sets the status bit when the pin is 0 and was 1 in the previous cycle.
- R8: Code 0xB sets the status bit on any change of the pin between consecutive cycles.
- R9: The status word is at byte address 0xA0, with bit n for pin n. A write clears each bit where the written data is 1 and leaves bits written as 0 unchanged.
- R10: Clearing a level-triggered bit while its level is still present leaves the bit set.
- R11: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R12: `irqOut` is the registered OR of all status bits. It rises one cycle after any bit is set and falls one cycle after all bits are clear.
- R13: Reads from unmapped or unaligned addresses return 0, and writes to them change no control word and no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte address for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| pinIn | input | 32 | Synchronized pin levels |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench visits every pin with all sixteen trigger codes. For each pair it drives a rise and a fall with clears in between, and checks the whole status word and the interrupt line after every step. A wrong decode, such as an unlisted code that behaves like an edge mode, would set a stray bit, and a swapped edge polarity would flag the wrong phase of the pulse. Other steps issue a clear in the same cycle as an event, and a clear while a level is still held; a design where the clear wins would drop the bit. A partial clear must leave the other bits alone. Writes to unaligned, out-of-range and near-miss addresses must be ignored, or a control word or a flag would change. A run of computed pin vectors with all pins in the any-change mode checks that status bits accumulate across many patterns.

// File: rtl/pid_pkg.sv
`timescale 1ns/1ps
package pid_pkg;

  localparam int MODE_LSB = 16;
  localparam int MODE_W   = 4;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF  = 4'h0,
    TRIG_LOW  = 4'h8,
    TRIG_RISE = 4'h9,
    TRIG_FALL = 4'hA,
    TRIG_BOTH = 4'hB,
    TRIG_HIGH = 4'hC
  } trig_e;

  // strobes from address decode to datapath
  typedef struct packed {
    logic cfgWr;
    logic clrWr;
    logic cfgRd;
    logic statRd;
  } strobe_t;

  function automatic logic trigHit(input logic [MODE_W-1:0] mode,
                                   input logic cur, input logic old);
    case (mode)
      TRIG_LOW:  trigHit = !cur;
      TRIG_HIGH: trigHit = cur;
      TRIG_RISE: trigHit = cur && !old;
      TRIG_FALL: trigHit = !cur && old;
      TRIG_BOTH: trigHit = cur ^ old;
      default:   trigHit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pid_ctrl.sv
`timescale 1ns/1ps
module pid_ctrl
  import pid_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFFSET = 'hA0,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobes,
  output logic [PIN_W-1:0]  pinSel
);

  logic [ADDR_W-3:0] wordIdx;
  logic              cfgHit;
  logic              statHit;

  assign wordIdx = addr[ADDR_W-1:2];
  assign cfgHit  = (addr[1:0] == 2'b00) && (int'(wordIdx) < NUM_PINS);
  assign statHit = (addr == STATUS_OFFSET);
  assign pinSel  = wordIdx[PIN_W-1:0];

  always_comb begin
    strobes        = '0;
    strobes.cfgRd  = cfgHit;
    strobes.statRd = statHit;
    strobes.cfgWr  = wrEn && cfgHit;
    strobes.clrWr  = wrEn && statHit;
  end

  // R13
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.cfgWr, strobes.clrWr}));

  // R13
  wr_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cfgWr || strobes.clrWr) |-> wrEn);

endmodule

// File: rtl/pid_datapath.sv
`timescale 1ns/1ps
module pid_datapath
  import pid_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [PIN_W-1:0]    pinSel,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);

  logic [MODE_W-1:0]   modeQ [NUM_PINS];
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] flagsQ;
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] clrMask;
  logic                irqQ;

  assign clrMask = strobes.clrWr ? wrData[NUM_PINS-1:0] : '0;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign evt[i] = trigHit(modeQ[i], pinIn[i], prevQ[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ[i] <= '0;
      end else if (strobes.cfgWr && pinSel == PIN_W'(i)) begin
        modeQ[i] <= wrData[MODE_LSB +: MODE_W];
      end
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      evt[i] |=> flagsQ[i]);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrWr && wrData[i] && !evt[i]) |=> !flagsQ[i]);

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!(modeQ[i] inside {TRIG_LOW, TRIG_HIGH, TRIG_RISE, TRIG_FALL, TRIG_BOTH})
       && !flagsQ[i]) |=> !flagsQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      flagsQ <= '0;
      irqQ   <= 1'b0;
    end else begin
      prevQ  <= pinIn;
      flagsQ <= (flagsQ & ~clrMask) | evt;
      irqQ   <= |flagsQ;
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    rdData = '0;
    if (strobes.cfgRd) begin
      rdData = DATA_W'(modeQ[pinSel]) << MODE_LSB;
    end else if (strobes.statRd) begin
      rdData = DATA_W'(flagsQ);
    end
  end

  // R12
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|flagsQ) |=> irqOut);

  // R12
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|flagsQ) |=> !irqOut);

endmodule

// File: rtl/pin_irq_detect.sv
`timescale 1ns/1ps
module pin_irq_detect
  import pid_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFFSET = 'hA0,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irqOut
);

  strobe_t          strobes;
  logic [PIN_W-1:0] pinSel;

  pid_ctrl #(
    .NUM_PINS      (NUM_PINS),
    .ADDR_W        (ADDR_W),
    .STATUS_OFFSET (STATUS_OFFSET)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (regWrEn),
    .addr    (regAddr),
    .strobes (strobes),
    .pinSel  (pinSel)
  );

  pid_datapath #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pinSel  (pinSel),
    .wrData  (regWrData),
    .pinIn   (pinIn),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/pin_irq_detect_tb.sv
`timescale 1ns/1ps
module pin_irq_detect_tb;

  localparam logic [7:0] STAT = 8'hA0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] pinIn = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pin_irq_detect u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pinIn     (pinIn),
    .irqOut    (irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] bitIf(input bit c, input int p);
    return c ? (32'h1 << p) : 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] expV;
    logic [31:0] vec;
    logic [31:0] prevV;
    logic [31:0] expFlags;

    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    rdReg(STAT, rd); check("R1 status", rd, 32'h0);
    rdReg(8'h14, rd); check("R1 cfg", rd, 32'h0);

    // sweep every pin with every trigger code
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 16; m++) begin
        wrReg(8'(p * 4), {12'hFFF, 4'(m), 16'hFFFF});
        rdReg(8'(p * 4), rd);
        check("R2 cfg readback", rd, {12'h0, 4'(m), 16'h0});

        wrReg(STAT, 32'hFFFF_FFFF);
        expV = bitIf(m == 8, p);
        rdReg(STAT, rd); check("R4/R3 idle low", rd, expV);
        step();
        check("R12 irq idle", {31'b0, irqOut}, {31'b0, expV != 0});

        @(negedge clk); pinIn = 32'h1 << p;
        step();
        expV = expV | bitIf(m == 9 || m == 11 || m == 12, p);
        rdReg(STAT, rd); check("R6/R5/R8 rise", rd, expV);
        step();
        check("R12 irq rise", {31'b0, irqOut}, {31'b0, expV != 0});

        wrReg(STAT, 32'hFFFF_FFFF);
        expV = bitIf(m == 12, p);
        rdReg(STAT, rd); check("R10 clear held high", rd, expV);

        @(negedge clk); pinIn = '0;
        step();
        expV = expV | bitIf(m == 8 || m == 10 || m == 11, p);
        rdReg(STAT, rd); check("R7/R4/R8 fall", rd, expV);

        wrReg(8'(p * 4), 32'h0);
        wrReg(STAT, 32'hFFFF_FFFF);
        rdReg(STAT, rd); check("R3 masked", rd, 32'h0);
        step(); step();
        check("R12 irq low", {31'b0, irqOut}, 32'h0);
      end
    end

    // R11 set and clear in the same cycle
    wrReg(8'h0C, 32'h0009_0000);
    @(negedge clk);
    pinIn = 32'h8; regWrEn = 1'b1; regAddr = STAT; regWrData = 32'h8;
    @(negedge clk);
    regWrEn = 1'b0;
    rdReg(STAT, rd); check("R11 set wins", rd, 32'h8);

    // R9 partial clear
    wrReg(8'h1C, 32'h0009_0000);
    @(negedge clk); pinIn = 32'h88;
    step();
    rdReg(STAT, rd); check("R9 two flags", rd, 32'h88);
    wrReg(STAT, 32'h8);
    rdReg(STAT, rd); check("R9 partial clear", rd, 32'h80);
    wrReg(STAT, 32'h0);
    rdReg(STAT, rd); check("R9 zero write", rd, 32'h80);

    // R13 unmapped and unaligned accesses
    wrReg(8'hA4, 32'hFFFF_FFFF);
    rdReg(STAT, rd); check("R13 near-miss clear", rd, 32'h80);
    wrReg(8'h1E, 32'h000C_0000);
    rdReg(8'h1C, rd); check("R13 unaligned write", rd, 32'h0009_0000);
    wrReg(8'h80, 32'h000B_0000);
    rdReg(8'h80, rd); check("R13 out of range", rd, 32'h0);
    rdReg(8'h0E, rd); check("R13 unaligned read", rd, 32'h0);
    rdReg(8'hA1, rd); check("R13 status alias", rd, 32'h0);

    // R8 many patterns, all pins any-change
    @(negedge clk); pinIn = '0;
    for (int p = 0; p < 32; p++) wrReg(8'(p * 4), 32'h000B_0000);
    wrReg(STAT, 32'hFFFF_FFFF);
    rdReg(STAT, rd); check("R8 start clean", rd, 32'h0);
    prevV = '0; expFlags = '0; vec = 32'h1234_5678;
    for (int k = 0; k < 60; k++) begin
      vec = vec * 32'd1664525 + 32'd1013904223;
      @(negedge clk); pinIn = vec;
      step();
      expFlags = expFlags | (vec ^ prevV);
      prevV = vec;
      rdReg(STAT, rd); check("R8 pattern", rd, expFlags);
      if (k % 8 == 7) begin
        wrReg(STAT, expFlags);
        expFlags = '0;
        rdReg(STAT, rd); check("R9 pattern clear", rd, 32'h0);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule